// File: doc/BRIEF.md
# ISP Link Bring-Up and Programming-Enable Sequencer

This block brings a serially programmed target into programming mode. A connect request turns on the output drivers for the target's reset, clock and data-out pins, holds reset and clock low for one delay period, raises reset for exactly one delay period and then lowers it again. Once that pulse is done, the block enables the external byte shifter. It also pulses a clear strobe so that the stored upper-address byte goes back to zero.

An enable request starts the programming-enable handshake. The block hands four command bytes, one at a time, to the external shifter through a go/done byte-transfer port. The attempt succeeds when the byte returned during the third transfer equals the second command byte. When an attempt fails, the block turns the shifter off, waits one delay, raises reset for one delay, lowers it, waits one more delay, turns the shifter back on and tries again. After a bounded number of attempts it reports an error. A disconnect request releases every pin and stops the shifter at once, from any state.

The delay length and the attempt limit are parameters. Success and error are flags that keep their value until the next connect or enable request.

Top module: `isp_link_seq`

## Requirements
- R1: After reset, every pin-enable output, every pin level output, the shifter enable, the byte-transfer go signal and both result flags are 0.
- R2: A connect request accepted while disconnected or idle does four things. It raises all three pin enables with reset, clock and data-out held low. It pulses the address-clear strobe for one cycle. It keeps reset low for DELAY_CYC cycles, then drives reset high for exactly DELAY_CYC cycles, then low. It raises the shifter enable 2*DELAY_CYC cycles after the pin enables rise.
- R3: Each attempt issues exactly four transfers in the order 0xAC, 0x53, 0x00, 0x00. The go signal and the byte stay steady until the shifter signals done.
- R4: An attempt succeeds only if the byte received on its third transfer equals 0x53. Bytes received on the other transfers are ignored. On success the pass flag is set and no further transfer is issued.
- R5: After a failed attempt, the shifter enable is 0 for exactly 3*DELAY_CYC cycles. In the middle of that window, reset is driven high for exactly DELAY_CYC cycles. Reset is never high while the shifter is enabled.
- R6: At most MAX_TRIES attempts are made. If every attempt fails, the fail flag is set after the last retry pulse. Pass and fail are never both 1.
- R7: Pass and fail keep their value until an accepted connect or enable request, which clears both.
- R8: A disconnect request, in any state, drops all pin enables, all pin levels, the shifter enable and the go signal on the next cycle, and ends any handshake in progress.
- R9: An enable request is ignored while the pins are disconnected or while a sequence is running. It causes no transfer and no extra attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| connect_req | input | 1 | Start pin bring-up and reset pulse |
| enable_req | input | 1 | Start programming-enable handshake |
| disconnect_req | input | 1 | Release all pins, stop shifter |
| xfer_done | input | 1 | Shifter finished current byte |
| xfer_rx | input | 8 | Byte received by shifter |
| xfer_go | output | 1 | Request a byte transfer |
| xfer_tx | output | 8 | Byte to send |
| shifter_en | output | 1 | Enable for the fast shifter |
| rst_oe | output | 1 | Target reset driver enable |
| rst_out | output | 1 | Target reset level |
| sck_oe | output | 1 | Serial clock driver enable |
| sck_out | output | 1 | Serial clock idle level |
| mosi_oe | output | 1 | Data-out driver enable |
| mosi_out | output | 1 | Data-out idle level |
| hiaddr_clr | output | 1 | One-cycle clear of stored upper-address byte |
| busy | output | 1 | Sequence in progress |
| pe_pass | output | 1 | Handshake succeeded |
| pe_fail | output | 1 | Handshake gave up |

## Verification
The handshake is driven by a shifter model that answers 0x53 on every transfer except the third of each failing attempt. A block that samples the wrong transfer would therefore pass where it should fail. The model varies how many attempts fail before a good echo: none, one, a few, exactly the limit, and more than the limit. This separates first-try success, retry counting and the off-by-one at the attempt limit. The mismatching third byte is 0x00, 0x52, 0xAC or 0x35, so a partial or wrong comparison shows up. Further tests cover enable requests while disconnected or busy, and a disconnect in the middle of a handshake.

// File: rtl/isp_seq_pkg.sv
package isp_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_CON_LOW,
    ST_CON_HIGH,
    ST_READY,
    ST_SEND,
    ST_RTY_PRE,
    ST_RTY_HIGH,
    ST_RTY_POST
  } seq_state_t;

  localparam logic [7:0] PE_OPCODE = 8'hAC;
  localparam logic [7:0] PE_ARG    = 8'h53;
  localparam logic [7:0] PE_ECHO   = 8'h53;
  localparam logic [1:0] ECHO_SLOT = 2'd2;
  localparam logic [1:0] LAST_SLOT = 2'd3;

  function automatic logic [7:0] pe_byte(input logic [1:0] slot);
    case (slot)
      2'd0:    pe_byte = PE_OPCODE;
      2'd1:    pe_byte = PE_ARG;
      default: pe_byte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/isp_wait_timer.sv
module isp_wait_timer #(
  parameter int DELAY_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expire
);
  localparam int CW = $clog2(DELAY_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(DELAY_CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)
      cnt_d = LOAD;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = (cnt_q == CW'(1));
endmodule

// File: rtl/isp_try_count.sv
module isp_try_count #(
  parameter int MAX_TRIES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic exhausted
);
  localparam int TW = $clog2(MAX_TRIES + 1);
  localparam logic [TW-1:0] LIMIT = TW'(MAX_TRIES);

  logic [TW-1:0] used_q, used_d;

  always_comb begin
    used_d = used_q;
    if (clr)
      used_d = inc ? TW'(1) : '0;
    else if (inc)
      used_d = used_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= used_d;
  end

  assign exhausted = (used_q >= LIMIT);
endmodule

// File: rtl/isp_pe_issuer.sv
module isp_pe_issuer
  import isp_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort,
  input  logic       start,
  input  logic       xfer_done,
  input  logic [7:0] xfer_rx,
  output logic       xfer_go,
  output logic [7:0] xfer_tx,
  output logic       fin,
  output logic       echo_ok
);
  logic [1:0] slot_q, slot_d;
  logic       go_q, go_d;
  logic       ok_q, ok_d;
  logic       step;

  assign step = go_q && xfer_done;

  always_comb begin
    slot_d = slot_q;
    go_d   = go_q;
    ok_d   = ok_q;
    if (abort) begin
      go_d   = 1'b0;
      slot_d = '0;
    end else if (start) begin
      go_d   = 1'b1;
      slot_d = '0;
      ok_d   = 1'b0;
    end else if (step) begin
      if (slot_q == ECHO_SLOT)
        ok_d = (xfer_rx == PE_ECHO);
      if (slot_q == LAST_SLOT) begin
        go_d   = 1'b0;
        slot_d = '0;
      end else begin
        slot_d = slot_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      go_q   <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      slot_q <= slot_d;
      go_q   <= go_d;
      ok_q   <= ok_d;
    end
  end

  assign xfer_go = go_q;
  assign xfer_tx = pe_byte(slot_q);
  assign fin     = step && (slot_q == LAST_SLOT) && !abort;
  assign echo_ok = ok_q;
endmodule

// File: rtl/isp_link_seq.sv
module isp_link_seq
  import isp_seq_pkg::*;
#(
  parameter int DELAY_CYC = 16,
  parameter int MAX_TRIES = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       connect_req,
  input  logic       enable_req,
  input  logic       disconnect_req,
  input  logic       xfer_done,
  input  logic [7:0] xfer_rx,
  output logic       xfer_go,
  output logic [7:0] xfer_tx,
  output logic       shifter_en,
  output logic       rst_oe,
  output logic       rst_out,
  output logic       sck_oe,
  output logic       sck_out,
  output logic       mosi_oe,
  output logic       mosi_out,
  output logic       hiaddr_clr,
  output logic       busy,
  output logic       pe_pass,
  output logic       pe_fail
);
  seq_state_t state_q, state_d;
  logic oe_q, oe_d;
  logic lvl_q, lvl_d;
  logic shen_q, shen_d;
  logic pass_q, pass_d;
  logic fail_q, fail_d;
  logic clr_q, clr_d;
  logic tmr_start, tmr_expire;
  logic cmd_start, cmd_fin, cmd_ok;
  logic try_clr, try_out;

  isp_wait_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (tmr_start),
    .expire (tmr_expire)
  );

  isp_try_count #(.MAX_TRIES(MAX_TRIES)) u_tries (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (try_clr),
    .inc       (cmd_start),
    .exhausted (try_out)
  );

  isp_pe_issuer u_issuer (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (disconnect_req),
    .start     (cmd_start),
    .xfer_done (xfer_done),
    .xfer_rx   (xfer_rx),
    .xfer_go   (xfer_go),
    .xfer_tx   (xfer_tx),
    .fin       (cmd_fin),
    .echo_ok   (cmd_ok)
  );

  always_comb begin
    state_d   = state_q;
    oe_d      = oe_q;
    lvl_d     = lvl_q;
    shen_d    = shen_q;
    pass_d    = pass_q;
    fail_d    = fail_q;
    clr_d     = 1'b0;
    tmr_start = 1'b0;
    cmd_start = 1'b0;
    try_clr   = 1'b0;
    if (disconnect_req) begin
      state_d = ST_OFF;
      oe_d    = 1'b0;
      lvl_d   = 1'b0;
      shen_d  = 1'b0;
    end else begin
      case (state_q)
        ST_OFF, ST_READY: begin
          if (connect_req) begin
            state_d   = ST_CON_LOW;
            oe_d      = 1'b1;
            lvl_d     = 1'b0;
            shen_d    = 1'b0;
            pass_d    = 1'b0;
            fail_d    = 1'b0;
            clr_d     = 1'b1;
            tmr_start = 1'b1;
          end else if (enable_req && state_q == ST_READY) begin
            state_d   = ST_SEND;
            pass_d    = 1'b0;
            fail_d    = 1'b0;
            try_clr   = 1'b1;
            cmd_start = 1'b1;
          end
        end
        ST_CON_LOW: begin
          if (tmr_expire) begin
            state_d   = ST_CON_HIGH;
            lvl_d     = 1'b1;
            tmr_start = 1'b1;
          end
        end
        ST_CON_HIGH: begin
          if (tmr_expire) begin
            state_d = ST_READY;
            lvl_d   = 1'b0;
            shen_d  = 1'b1;
          end
        end
        ST_SEND: begin
          if (cmd_fin) begin
            if (cmd_ok) begin
              state_d = ST_READY;
              pass_d  = 1'b1;
            end else begin
              state_d   = ST_RTY_PRE;
              shen_d    = 1'b0;
              tmr_start = 1'b1;
            end
          end
        end
        ST_RTY_PRE: begin
          if (tmr_expire) begin
            state_d   = ST_RTY_HIGH;
            lvl_d     = 1'b1;
            tmr_start = 1'b1;
          end
        end
        ST_RTY_HIGH: begin
          if (tmr_expire) begin
            state_d   = ST_RTY_POST;
            lvl_d     = 1'b0;
            tmr_start = 1'b1;
          end
        end
        ST_RTY_POST: begin
          if (tmr_expire) begin
            shen_d = 1'b1;
            if (try_out) begin
              state_d = ST_READY;
              fail_d  = 1'b1;
            end else begin
              state_d   = ST_SEND;
              cmd_start = 1'b1;
            end
          end
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      oe_q    <= 1'b0;
      lvl_q   <= 1'b0;
      shen_q  <= 1'b0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      oe_q    <= oe_d;
      lvl_q   <= lvl_d;
      shen_q  <= shen_d;
      pass_q  <= pass_d;
      fail_q  <= fail_d;
      clr_q   <= clr_d;
    end
  end

  assign shifter_en = shen_q;
  assign rst_oe     = oe_q;
  assign sck_oe     = oe_q;
  assign mosi_oe    = oe_q;
  assign rst_out    = lvl_q;
  assign sck_out    = 1'b0;
  assign mosi_out   = 1'b0;
  assign hiaddr_clr = clr_q;
  assign busy       = (state_q != ST_OFF) && (state_q != ST_READY);
  assign pe_pass    = pass_q;
  assign pe_fail    = fail_q;
endmodule

// File: rtl/isp_seq_chk.sv
module isp_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       connect_req,
  input logic       enable_req,
  input logic       disconnect_req,
  input logic       xfer_done,
  input logic       xfer_go,
  input logic [7:0] xfer_tx,
  input logic       shifter_en,
  input logic       rst_oe,
  input logic       rst_out,
  input logic       busy,
  input logic       pe_pass,
  input logic       pe_fail
);
  assert_oe_rise_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_oe) |-> !rst_out);

  assert_xfer_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_go && !xfer_done && !disconnect_req) |=> (xfer_go && $stable(xfer_tx)));

  assert_rst_vs_shifter_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out |-> !shifter_en);

  assert_result_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pe_pass && pe_fail));

  assert_pass_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_pass && !connect_req && !enable_req && !disconnect_req) |=> pe_pass);

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    disconnect_req |=> (!rst_oe && !rst_out && !shifter_en && !xfer_go));

  assert_no_xfer_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_oe |-> (!xfer_go && !busy));
endmodule

bind isp_link_seq isp_seq_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .connect_req    (connect_req),
  .enable_req     (enable_req),
  .disconnect_req (disconnect_req),
  .xfer_done      (xfer_done),
  .xfer_go        (xfer_go),
  .xfer_tx        (xfer_tx),
  .shifter_en     (shifter_en),
  .rst_oe         (rst_oe),
  .rst_out        (rst_out),
  .busy           (busy),
  .pe_pass        (pe_pass),
  .pe_fail        (pe_fail)
);

// File: tb/tb_isp_link_seq.sv
`timescale 1ns/1ps
module tb_isp_link_seq;
  localparam int D    = 3;
  localparam int MAXT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic connect_req = 1'b0, enable_req = 1'b0, disconnect_req = 1'b0;
  logic xfer_done = 1'b0;
  logic [7:0] xfer_rx = 8'h00;
  logic xfer_go, shifter_en, rst_oe, rst_out, sck_oe, sck_out, mosi_oe, mosi_out;
  logic hiaddr_clr, busy, pe_pass, pe_fail;
  logic [7:0] xfer_tx;

  always #4 clk = ~clk;

  isp_link_seq #(.DELAY_CYC(D), .MAX_TRIES(MAXT)) dut (
    .clk(clk), .rst_n(rst_n), .connect_req(connect_req), .enable_req(enable_req),
    .disconnect_req(disconnect_req), .xfer_done(xfer_done), .xfer_rx(xfer_rx),
    .xfer_go(xfer_go), .xfer_tx(xfer_tx), .shifter_en(shifter_en),
    .rst_oe(rst_oe), .rst_out(rst_out), .sck_oe(sck_oe), .sck_out(sck_out),
    .mosi_oe(mosi_oe), .mosi_out(mosi_out), .hiaddr_clr(hiaddr_clr),
    .busy(busy), .pe_pass(pe_pass), .pe_fail(pe_fail));

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // shifter model and monitor
  int fails_ok = 0;
  logic [7:0] bad_rx = 8'h00;
  int lat = 0, bidx = 0, attempts = 0, seq_bad = 0, ntx = 0;
  int hw = 0, pulses = 0, wid_bad = 0, off = 0, spans_conn = 0, spans_rty = 0;
  int span_bad = 0, viol = 0, clr_pulses = 0;

  always @(negedge clk) begin
    if (xfer_done) begin
      xfer_done <= 1'b0;
    end else if (xfer_go) begin
      if (lat == 1) begin
        lat = 0;
        if (bidx == 0) attempts++;
        if (xfer_tx != (bidx == 0 ? 8'hAC : bidx == 1 ? 8'h53 : 8'h00)) seq_bad++;
        ntx++;
        xfer_rx   <= (bidx == 2 && attempts <= fails_ok) ? bad_rx : 8'h53;
        xfer_done <= 1'b1;
        bidx = (bidx + 1) % 4;
      end else lat++;
    end else lat = 0;

    if (rst_out) hw++;
    else if (hw > 0) begin pulses++; if (hw != D) wid_bad++; hw = 0; end

    if (!rst_oe) off = 0;
    else if (!shifter_en) off++;
    else if (off > 0) begin
      if (off == 2*D) spans_conn++;
      else if (off == 3*D) spans_rty++;
      else span_bad++;
      off = 0;
    end
    if (rst_out && shifter_en) viol++;
    if (hiaddr_clr) clr_pulses++;
  end

  task automatic clr_mon();
    @(posedge clk); #1;
    attempts = 0; seq_bad = 0; ntx = 0; pulses = 0; wid_bad = 0;
    spans_conn = 0; spans_rty = 0; span_bad = 0; viol = 0; clr_pulses = 0; bidx = 0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
    repeat (2) @(negedge clk);
  endtask

  // {fails_before_good, bad third byte, expect pass, expected attempts}
  localparam logic [23:0] VEC [5] = '{
    {8'd0, 8'h00, 1'b1, 7'd1},
    {8'd1, 8'h52, 1'b1, 7'd2},
    {8'd3, 8'hAC, 1'b1, 7'd4},
    {8'd4, 8'h35, 1'b0, 7'd4},
    {8'd9, 8'h00, 1'b0, 7'd4}
  };

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected 0", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 oe", {rst_oe, sck_oe, mosi_oe}, 0);
    chk("R1 levels", {rst_out, sck_out, mosi_out}, 0);
    chk("R1 shifter/go", {shifter_en, xfer_go}, 0);
    chk("R1 flags", {pe_pass, pe_fail}, 0);

    // R9 enable while disconnected
    clr_mon();
    pulse(enable_req);
    repeat (20) @(negedge clk);
    chk("R9 no xfer when off", ntx, 0);
    chk("R9 flags when off", {pe_pass, pe_fail, busy}, 0);

    // R2 connect
    clr_mon();
    pulse(connect_req);
    chk("R2 oe", {rst_oe, sck_oe, mosi_oe}, 7);
    chk("R2 levels low", {rst_out, sck_out, mosi_out}, 0);
    wait_idle();
    chk("R2 addr clear pulse", clr_pulses, 1);
    chk("R2 one reset pulse", pulses, 1);
    chk("R2 pulse width", wid_bad, 0);
    chk("R2 shifter delay", spans_conn, 1);
    chk("R2 shifter on", shifter_en, 1);
    chk("R2 reset low after", rst_out, 0);

    // table-driven handshake: R3 R4 R5 R6 R7
    for (int v = 0; v < 5; v++) begin
      fails_ok = int'(VEC[v][23:16]);
      bad_rx   = VEC[v][15:8];
      clr_mon();
      pulse(enable_req);
      chk("R7 cleared by enable", {pe_pass, pe_fail}, 0);
      wait_idle();
      chk("R4 R6 pass flag", pe_pass, int'(VEC[v][7]));
      chk("R6 fail flag", pe_fail, int'(!VEC[v][7]));
      chk("R6 attempts", attempts, int'(VEC[v][6:0]));
      chk("R3 byte order", seq_bad, 0);
      chk("R3 transfer count", ntx, 4 * int'(VEC[v][6:0]));
      chk("R5 retry pulses", pulses, int'(VEC[v][6:0]) - int'(VEC[v][7]));
      chk("R5 pulse width", wid_bad, 0);
      chk("R5 shifter-off windows", spans_rty, int'(VEC[v][6:0]) - int'(VEC[v][7]));
      chk("R5 bad windows", span_bad, 0);
      chk("R5 reset with shifter", viol, 0);
      repeat (10) @(negedge clk);
      chk("R7 flags hold", {pe_pass, pe_fail}, {VEC[v][7], !VEC[v][7]});
      chk("R4 no extra transfers", ntx, 4 * int'(VEC[v][6:0]));
    end

    // R9 enable while busy
    fails_ok = 9; bad_rx = 8'h00;
    clr_mon();
    pulse(enable_req);
    repeat (8) @(negedge clk);
    pulse(enable_req);
    repeat (20) @(negedge clk);
    pulse(enable_req);
    wait_idle();
    chk("R9 attempts while busy", attempts, MAXT);
    chk("R9 fail after busy enables", pe_fail, 1);

    // R7 connect clears flags
    pulse(connect_req);
    chk("R7 cleared by connect", {pe_pass, pe_fail}, 0);
    wait_idle();

    // R8 disconnect mid-handshake
    clr_mon();
    pulse(enable_req);
    repeat (25) @(negedge clk);
    disconnect_req = 1'b1;
    @(negedge clk);
    disconnect_req = 1'b0;
    chk("R8 oe released", {rst_oe, sck_oe, mosi_oe}, 0);
    chk("R8 levels low", {rst_out, sck_out, mosi_out}, 0);
    chk("R8 shifter/go off", {shifter_en, xfer_go, busy}, 0);
    clr_mon();
    repeat (30) @(negedge clk);
    chk("R8 no activity after", ntx + pulses, 0);

    // reconnect and succeed
    fails_ok = 0;
    pulse(connect_req);
    wait_idle();
    clr_mon();
    pulse(enable_req);
    wait_idle();
    chk("R4 pass after reconnect", pe_pass, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule